// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that an SDRAM read or write burst visits. A one-cycle start pulse captures a starting column, a 3-bit burst-length code and an order select. From the next cycle on, the block presents one column per clock with a valid flag. A last flag marks the closing beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats only reorder the low 0 to 3 column bits inside an aligned window. The upper column bits keep their starting value for the whole burst. Two orders are available. In the sequential order the low bits count up and wrap inside the window. In the interleaved order the low bits are the starting low bits XORed with the beat index. A full-page burst walks the whole column field in sequential order and keeps going until a stop input ends it. A new start always takes over at once, even in the middle of a burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and after it until the first start, valid_o and last_o are 0 and col_o is 0.
- R2: A start_i sampled high at a clock edge makes the first beat appear right after that edge, with valid_o = 1 and col_o equal to the captured start_col_i.
- R3: Sequential fixed bursts (ilv_i = 0) of N = 2, 4 or 8 beats give beat k the low log2(N) bits ((start + k) mod N). All higher column bits equal the start column. Example: N = 8 from 5 gives 5,6,7,0,1,2,3,4.
- R4: Interleaved fixed bursts (ilv_i = 1) give beat k the low log2(N) bits (start_low XOR k), with the upper bits held. Example: N = 8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: bl_code_i selects the length: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page. Codes 3'b100, 3'b101 and 3'b110 give a single beat.
- R6: A fixed burst holds valid_o high for exactly N consecutive cycles. last_o is high on the N-th beat only, and valid_o drops after it unless a new start arrives.
- R7: A full-page burst is always sequential and ignores ilv_i. col_o increments by one per beat across all 9 bits and wraps from 511 to 0.
- R8: A full-page burst continues until stop_i is sampled high during it. valid_o is low from the following cycle on, and last_o stays 0 throughout a full-page burst.
- R9: stop_i has no effect while idle or during a fixed-length burst.
- R10: A start_i during an active burst abandons it. The new burst's first beat appears on the next cycle, and a start on a final beat chains the bursts with no gap.
- R11: start_col_i, bl_code_i and ilv_i are only captured at a start. Changes to them during a burst do not alter it.
- R12: col_o reads 0 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start_i | input | 1 | One-cycle burst request |
| start_col_i | input | 9 | Starting column address |
| bl_code_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Ends an active full-page burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Two behaviours are hard to reach from the ports. The first is the full-page wrap from column 511 back to 0, which needs hundreds of beats. The bench starts a full-page burst near the top of the field with the interleave select raised, and lets it run well past the wrap before it asserts stop. The second is a restart that lands exactly on a burst's last beat or in its middle. The bench times these starts by counting cycles against its own queue model, and it also fires start and stop together.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  // Burst-length codes on bl_code_i
  typedef enum logic [2:0] {
    BLC_ONE   = 3'b000,
    BLC_TWO   = 3'b001,
    BLC_FOUR  = 3'b010,
    BLC_EIGHT = 3'b011,
    BLC_PAGE  = 3'b111
  } blen_code_e;

  localparam int unsigned CODE_W = 3;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_i) begin
          if (!rst_n_i) chain_q[s] <= 1'b0;
          else          chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_i) begin
          if (!rst_n_i) chain_q[s] <= 1'b0;
          else          chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              full_o,
  output logic [COL_W-1:0]  mask_o,
  output logic [COL_W-1:0]  last_idx_o
);
  always_comb begin
    full_o     = 1'b0;
    mask_o     = '0;
    unique case (code_i)
      BLC_TWO:   mask_o = COL_W'(1);
      BLC_FOUR:  mask_o = COL_W'(3);
      BLC_EIGHT: mask_o = COL_W'(7);
      BLC_PAGE: begin
        full_o = 1'b1;
        mask_o = '1;
      end
      default:   mask_o = '0;
    endcase
    // window size minus one equals the mask for the fixed lengths
    last_idx_o = mask_o;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             ilv_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] last_idx_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             full_o,
  output logic             at_last_o
);
  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, mask_q, last_idx_q;
  logic             ilv_q, full_q;
  logic             ld_en, adv_en;

  assign ld_en  = start_i;
  assign adv_en = active_q & ~start_i;

  // next state
  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (ld_en) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (adv_en) begin
      if (full_q) begin
        if (stop_i) active_d = 1'b0;
        else        beat_d   = beat_q + COL_W'(1);
      end else if (beat_q == last_idx_q) begin
        active_d = 1'b0;
      end else begin
        beat_d = beat_q + COL_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (ld_en | adv_en) begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  // burst configuration, loaded only at a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      mask_q     <= '0;
      last_idx_q <= '0;
      ilv_q      <= 1'b0;
      full_q     <= 1'b0;
    end else if (ld_en) begin
      base_q     <= start_col_i;
      mask_q     <= mask_i;
      last_idx_q <= last_idx_i;
      ilv_q      <= ilv_i & ~full_i;
      full_q     <= full_i;
    end
  end

  assign active_o  = active_q;
  assign beat_o    = beat_q;
  assign base_o    = base_q;
  assign mask_o    = mask_q;
  assign ilv_o     = ilv_q;
  assign full_o    = full_q;
  assign at_last_o = active_q & ~full_q & (beat_q == last_idx_q);

  // R6: a fixed burst never counts beyond its final beat
  p_beat_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_q) |-> (beat_q <= last_idx_q));

  // R10: a start always restarts the beat count
  p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && beat_q == '0));
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int unsigned COL_W = 9
) (
  input  logic             active_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum, seq_col, ilv_col, pick;

  always_comb begin
    sum     = base_i + beat_i;
    seq_col = (base_i & ~mask_i) | (sum & mask_i);
    ilv_col = base_i ^ (beat_i & mask_i);
    pick    = ilv_i ? ilv_col : seq_col;
    col_o   = active_i ? pick : '0;
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W       = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              ilv_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic             rst_q_n;
  logic             dec_full;
  logic [COL_W-1:0] dec_mask, dec_last;
  logic             act, ilv_q, full_q, at_last;
  logic [COL_W-1:0] beat, base, mask_q;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_q_n)
  );

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i(bl_code_i), .full_o(dec_full),
    .mask_o(dec_mask), .last_idx_o(dec_last)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_q_n),
    .start_i(start_i), .stop_i(stop_i),
    .start_col_i(start_col_i), .ilv_i(ilv_i),
    .full_i(dec_full), .mask_i(dec_mask), .last_idx_i(dec_last),
    .active_o(act), .beat_o(beat), .base_o(base), .mask_o(mask_q),
    .ilv_o(ilv_q), .full_o(full_q), .at_last_o(at_last)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .active_i(act), .base_i(base), .beat_i(beat),
    .mask_i(mask_q), .ilv_i(ilv_q), .col_o(col_o)
  );

  assign valid_o = act;
  assign last_o  = at_last;

  // R2: the first beat follows the start and carries the start column
  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R6: last only while valid, and the burst closes after it
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    last_o |-> valid_o);
  p_after_last_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (last_o && !start_i) |=> !valid_o);

  // R3: upper column bits stay fixed inside a fixed burst
  p_upper_held_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && !full_q && !start_i) |=>
      (!valid_o || ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))));

  // R7: full page steps by one each beat, modulo the column field
  p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && full_q && !start_i && !stop_i) |=>
      (col_o == $past(col_o) + COL_W'(1)));

  // R8: a stop ends a full page, which never shows last
  p_page_stop_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && full_q && stop_i && !start_i) |=> !valid_o);
  p_page_nolast_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && full_q) |-> !last_o);

  // R12: idle column is zero
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_o |-> (col_o == '0));
endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;
  localparam int COLS = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [8:0] start_col_i;
  logic [2:0] bl_code_i;
  logic       ilv_i;
  logic       stop_i;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string tag_prev = "R1";

  always #4 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // behavioural model: queue of pending beats or a running page pointer
  int exp_col_q[$];
  bit exp_last_q[$];
  bit page_on  = 0;
  int page_col = 0;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_col_q.delete();
      exp_last_q.delete();
      page_on = 0;
    end else if (start_i) begin
      exp_col_q.delete();
      exp_last_q.delete();
      if (bl_code_i == 3'b111) begin
        page_on  = 1;
        page_col = int'(start_col_i);
      end else begin
        int n, lo, base;
        page_on = 0;
        n    = len_of(bl_code_i);
        lo   = int'(start_col_i) % n;
        base = int'(start_col_i) - lo;
        for (int k = 0; k < n; k++) begin
          exp_col_q.push_back(ilv_i ? base + (lo ^ k) : base + ((lo + k) % n));
          exp_last_q.push_back(k == n - 1);
        end
      end
    end else if (page_on) begin
      if (stop_i) page_on = 0;
      else        page_col = (page_col + 1) % COLS;
    end else if (exp_col_q.size() > 0) begin
      void'(exp_col_q.pop_front());
      void'(exp_last_q.pop_front());
    end
  end

  task automatic check(input string tag);
    bit ev, el;
    int ec;
    ev = page_on || (exp_col_q.size() > 0);
    ec = page_on ? page_col : (exp_col_q.size() > 0 ? exp_col_q[0] : 0);
    el = !page_on && (exp_last_q.size() > 0) && exp_last_q[0];
    n_tests++;
    if (valid_o !== ev || int'(col_o) != ec || last_o !== el) begin
      n_fail++;
      $display("FAIL %s: valid=%0b col=%0d last=%0b expected valid=%0b col=%0d last=%0b",
               tag, valid_o, col_o, last_o, ev, ec, el);
    end
  endtask

  // one cycle: check what the previous stimulus produced, then drive anew
  task automatic cyc(input bit st, input int col, input int code,
                     input bit ilv, input bit stp, input string tag);
    @(negedge clk);
    check(tag_prev);
    start_i     = st;
    start_col_i = 9'(col);
    bl_code_i   = 3'(code);
    ilv_i       = ilv;
    stop_i      = stp;
    tag_prev    = tag;
  endtask

  task automatic idle(input int n, input bit stp, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, stp, tag);
  endtask

  task automatic burst(input int col, input int code, input bit ilv, input string tag);
    cyc(1, col, code, ilv, 0, tag);
    idle(len_of(3'(code)) + 1, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; start_col_i = 0; bl_code_i = 0; ilv_i = 0; stop_i = 0;
    idle(4, 0, "R1");
    @(negedge clk) rst_n = 1;
    idle(5, 0, "R1");

    // R2 R3: sequential bursts, upper bits held
    burst(5, 3, 0, "R3");
    burst(9'h1A1, 2, 0, "R3");
    burst(9'h0F2, 2, 0, "R3");
    burst(9'h133, 1, 0, "R2");
    // R4: interleaved bursts
    burst(5, 3, 1, "R4");
    burst(9'h1A1, 2, 1, "R4");
    burst(9'h0F2, 2, 1, "R4");
    burst(9'h0EE, 3, 1, "R4");
    burst(9'h133, 1, 1, "R4");
    // R5: length codes including the single-beat fallbacks
    burst(9'h077, 0, 0, "R5");
    burst(9'h0A6, 4, 1, "R5");
    burst(9'h0A7, 5, 0, "R5");
    burst(9'h1FF, 6, 1, "R5");
    // R6 R9 R11: stop and input changes during a fixed burst
    cyc(1, 9'h0C3, 3, 0, 0, "R6");
    cyc(0, 9'h1FF, 7, 1, 1, "R9");
    cyc(0, 9'h000, 1, 1, 1, "R11");
    idle(7, 1, "R9");
    idle(3, 1, "R9");
    // R10: restart mid burst, and chained on the last beat
    cyc(1, 2, 3, 0, 0, "R10");
    idle(3, 0, "R10");
    cyc(1, 9'h15D, 3, 1, 0, "R10");
    idle(7, 0, "R10");
    cyc(1, 9'h046, 2, 0, 0, "R10");
    idle(5, 0, "R10");
    // R7 R8: full page across the wrap, interleave ignored
    cyc(1, 510, 7, 1, 0, "R7");
    idle(520, 0, "R7");
    cyc(0, 0, 0, 0, 1, "R8");
    idle(3, 0, "R8");
    // R8 R10: start with stop together takes the new page burst
    cyc(1, 9'h100, 7, 0, 0, "R8");
    idle(4, 0, "R8");
    cyc(1, 9'h1F0, 7, 0, 1, "R10");
    idle(20, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R8");
    idle(3, 0, "R12");
    // R1: reset in the middle of a burst returns to idle
    cyc(1, 9'h033, 3, 0, 0, "R1");
    idle(2, 0, "R1");
    @(negedge clk) rst_n = 0;
    idle(3, 0, "R1");
    @(negedge clk) rst_n = 1;
    idle(4, 0, "R1");
    burst(9'h0D4, 3, 0, "R3");
    idle(1, 0, "R12");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule